// File: doc/BRIEF.md
# Doorbell Interrupt Register

A single memory-mapped register that lets a host processor ring doorbells toward one remote processor core. The host writes a 32-bit word. The upper 28 bits each name an interrupt source, and bit 0 is a commit trigger. Sources named in a triggered write become pending. Each pending source stays pending until the remote core acknowledges it.

The remote core sees one interrupt line, which is high while any source is pending. It also has a 28-bit acknowledge vector for clearing the sources it has handled. When the host reads the register, it gets the live pending status. The host can therefore poll whether a doorbell it rang has been serviced. One instance serves one remote core.

Top module: `doorbell_irq_reg`

## Requirements
- R1: There are 28 sources. Source n maps to register bit n+4, in both the write word and the read word.
- R2: A write with bit 0 set marks as pending, at that clock edge, every source whose bit is 1 in the write word.
- R3: A write with bit 0 clear changes no pending bit, whatever its source bits hold.
- R4: Writing 0 to a source bit never clears it. Only an acknowledge clears a pending source.
- R5: A 1 on ack_i[n] clears pending source n at the next clock edge.
- R6: If a triggered write sets source n in the same cycle that ack_i[n] is 1, source n is pending after the edge.
- R7: irq_o is a register. In each cycle it equals the OR of all pending bits as they stood one cycle earlier.
- R8: A read returns the pending vector on bits 31..4 and 0 on bits 3..0. The value appears on rdata_o in the cycle after rd_en_i and holds until the next read. A read in the same cycle as a write returns the state before the write.
- R9: Reset (rst_ni low) clears all pending bits, irq_o and rdata_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| wdata_i | input | 32 | Host write word: bit 0 trigger, bits 31..4 sources |
| rdata_o | output | 32 | Read word, valid the cycle after rd_en_i |
| ack_i | input | 28 | Remote acknowledge, one bit per source |
| irq_o | output | 1 | Interrupt to the remote core |

## Verification
The bound checker runs on every cycle. It checks that a triggered write lands every named source, and that an untriggered write adds none. It checks that pending bits only fall under an acknowledge and that acknowledged bits fall unless they are set in the same cycle. It also checks the one-cycle latency of irq_o and of read data.

Other behaviours appear only in the bench's scenarios, which compare against a model held in the bench:
- the exact mapping from source to bit, swept one source at a time;
- the priority of a set over an acknowledge, seen through reads;
- a read that coincides with a write;
- reset in the middle of a run.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned DB_DATA_W   = 32;
  localparam int unsigned DB_NUM_SRC  = 28;
  localparam int unsigned DB_SRC_LSB  = 4;
  localparam int unsigned DB_TRIG_BIT = 0;
endpackage

// File: rtl/doorbell_wr_decode.sv
module doorbell_wr_decode #(
  parameter int unsigned DATA_W   = doorbell_pkg::DB_DATA_W,
  parameter int unsigned NUM_SRC  = doorbell_pkg::DB_NUM_SRC,
  parameter int unsigned SRC_LSB  = doorbell_pkg::DB_SRC_LSB,
  parameter int unsigned TRIG_BIT = doorbell_pkg::DB_TRIG_BIT
) (
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_SRC-1:0] set_o
);
  logic trig;
  logic unused_wdata;

  assign trig = wr_en_i & wdata_i[TRIG_BIT];
  // reserved bits between trigger and sources are ignored
  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_set
    assign set_o[i] = trig & wdata_i[SRC_LSB+i];
  end
endmodule

// File: rtl/doorbell_pend_bank.sv
module doorbell_pend_bank #(
  parameter int unsigned NUM_SRC = doorbell_pkg::DB_NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_o[i] <= 1'b0;
      else if (set_i[i])  pend_o[i] <= 1'b1;  // set beats ack
      else if (ack_i[i])  pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/doorbell_rd_port.sv
module doorbell_rd_port #(
  parameter int unsigned DATA_W  = doorbell_pkg::DB_DATA_W,
  parameter int unsigned NUM_SRC = doorbell_pkg::DB_NUM_SRC,
  parameter int unsigned SRC_LSB = doorbell_pkg::DB_SRC_LSB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    rd_word[SRC_LSB +: NUM_SRC] = pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= |pend_i;
      if (rd_en_i) rdata_o <= rd_word;
    end
  end
endmodule

// File: rtl/doorbell_irq_reg.sv
module doorbell_irq_reg #(
  parameter int unsigned DATA_W   = doorbell_pkg::DB_DATA_W,
  parameter int unsigned NUM_SRC  = doorbell_pkg::DB_NUM_SRC,
  parameter int unsigned SRC_LSB  = doorbell_pkg::DB_SRC_LSB,
  parameter int unsigned TRIG_BIT = doorbell_pkg::DB_TRIG_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] set_mask;
  logic [NUM_SRC-1:0] pend_q;

  doorbell_wr_decode #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB), .TRIG_BIT(TRIG_BIT)
  ) u_dec (
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .set_o  (set_mask)
  );

  doorbell_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_mask),
    .ack_i (ack_i),
    .pend_o(pend_q)
  );

  doorbell_rd_port #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB)
  ) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en_i),
    .pend_i (pend_q),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/doorbell_irq_reg_chk.sv
module doorbell_irq_reg_chk #(
  parameter int unsigned DATA_W   = doorbell_pkg::DB_DATA_W,
  parameter int unsigned NUM_SRC  = doorbell_pkg::DB_NUM_SRC,
  parameter int unsigned SRC_LSB  = doorbell_pkg::DB_SRC_LSB,
  parameter int unsigned TRIG_BIT = doorbell_pkg::DB_TRIG_BIT
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic [NUM_SRC-1:0] ack_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_i
);
  logic               trig;
  logic [NUM_SRC-1:0] src_bits;
  logic [DATA_W-1:0]  exp_word;

  assign trig     = wr_en_i && wdata_i[TRIG_BIT];
  assign src_bits = wdata_i[SRC_LSB +: NUM_SRC];
  always_comb begin
    exp_word = '0;
    exp_word[SRC_LSB +: NUM_SRC] = pend_i;
  end

  p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> ((pend_i & $past(src_bits)) == $past(src_bits)));

  p_no_trig_no_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig |=> ((pend_i & ~$past(pend_i)) == '0));

  p_only_ack_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~pend_i & $past(pend_i) & ~$past(ack_i)) == '0));

  p_ack_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig ? ((ack_i & ~src_bits) != '0) : (ack_i != '0)) |=>
      ((pend_i & $past(trig ? (ack_i & ~src_bits) : ack_i)) == '0));

  p_irq_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|pend_i)));

  p_read_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rdata_o == $past(exp_word)));

  p_read_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

bind doorbell_irq_reg doorbell_irq_reg_chk #(
  .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB), .TRIG_BIT(TRIG_BIT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .ack_i  (ack_i),
  .irq_o  (irq_o),
  .pend_i (pend_q)
);

// File: tb/tb_doorbell_irq_reg.sv
module tb_doorbell_irq_reg;
  localparam int N = 28;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          rd_en_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  ack_i = '0;
  logic          irq_o;

  int errors = 0;
  int checks = 0;

  logic [N-1:0] m_pend = '0;
  logic [31:0]  m_rdata = '0;
  logic         m_irq = 1'b0;

  always #2.5 clk_i = ~clk_i;

  doorbell_irq_reg dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_i(ack_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the given inputs; model updated and outputs compared
  task automatic step(input logic wr, input logic [31:0] wd, input logic rd,
                      input logic [N-1:0] ack, input string req);
    logic [N-1:0] set;
    wr_en_i = wr; wdata_i = wd; rd_en_i = rd; ack_i = ack;
    set = (wr && wd[0]) ? wd[31:4] : '0;
    if (rd) m_rdata = {m_pend, 4'b0000};
    m_irq  = |m_pend;
    m_pend = (m_pend & ~ack) | set;
    @(posedge clk_i); #1;
    check({req, "/R7 irq"}, {31'b0, irq_o}, {31'b0, m_irq});
    if (rd) check({req, "/R8 read"}, rdata_o, m_rdata);
    wr_en_i = 1'b0; rd_en_i = 1'b0; ack_i = '0; wdata_i = '0;
  endtask

  task automatic rd_chk(input string req);
    step(1'b0, '0, 1'b1, '0, req);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R9 reset rdata", rdata_o, 32'h0);
    check("R9 reset irq", {31'b0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    rd_chk("R9");

    // per-source sweep
    for (int n = 0; n < N; n++) begin
      step(1'b1, (32'h1 << (n + 4)), 1'b0, '0, "R3 no trigger");
      rd_chk("R3");
      step(1'b1, (32'h1 << (n + 4)) | 32'h1, 1'b0, '0, "R2 set");
      rd_chk("R1 map");
      step(1'b1, 32'h0000_0001, 1'b0, '0, "R4 zero write");
      step(1'b1, 32'hFFFF_FFFE, 1'b0, '0, "R3 untriggered ones");
      rd_chk("R4");
      step(1'b0, '0, 1'b0, (N'(1) << n), "R5 ack");
      rd_chk("R5");
      step(1'b0, '0, 1'b0, '0, "R7 idle");
    end

    // multi-bit patterns, reserved bits set
    step(1'b1, 32'hA5A5_A5AF, 1'b0, '0, "R2 pattern");
    rd_chk("R8 reserved zero");
    step(1'b1, 32'h5A5A_5A5F, 1'b1, '0, "R8 read during write");
    rd_chk("R2");
    step(1'b0, '0, 1'b0, 28'h00F_F0F0, "R5 partial ack");
    rd_chk("R5");
    // set and ack collide
    step(1'b1, 32'h0000_0031, 1'b0, 28'h000_0003, "R6 set vs ack");
    rd_chk("R6");
    step(1'b0, '0, 1'b0, '1, "R5 ack all");
    rd_chk("R5 all");
    step(1'b0, '0, 1'b0, '0, "R7 drop");
    step(1'b1, 32'hFFFF_FFF1, 1'b0, '1, "R6 all vs ack all");
    rd_chk("R6 all");

    // mid-run reset
    #1 rst_ni = 1'b0;
    #1;
    check("R9 mid reset rdata", rdata_o, 32'h0);
    check("R9 mid reset irq", {31'b0, irq_o}, 32'h0);
    m_pend = '0; m_rdata = '0;
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    rd_chk("R9 after reset");
    rd_chk("R9 irq low");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule